// File: doc/BRIEF.md
# Multi-Grant Age-Ordered Issue Selector

This block picks which waiting entries of an issue queue go to execution in a given cycle. Entries may be placed in any free slot. Their relative age is kept in an N-by-N bit matrix rather than in slot position. Bit (r,c) of the matrix is 1 when the entry in slot c is older than the entry in slot r, and the diagonal is always 0.

Every cycle, each bidding entry masks its matrix row with the live bid vector and counts the ones that remain. That count is the number of older bidders in its own class. The entry is granted when the count is below the issue width. All rows are evaluated in parallel, so each execution class receives its oldest ready entries in one step, up to the issue width. A dispatch places an entry as the youngest of its class. In criticality mode, an entry flagged critical is placed ahead of every non-critical entry of its class and behind the critical entries already present.

A granted entry leaves its slot at the next clock edge. That slot is then reported on the freed output, and it may be dispatched into again.

Top module: `age_issue_sel`

## Requirements
- R1: After reset no slot is occupied: with every bid bit set, `grant_o` and `freed_o` are all zero.
- R2: A grant is given only to a slot that bids and is occupied. Bid bits of empty slots have no effect on `grant_o`.
- R3: When a class has at most ISSUE_W occupied bidders, every one of them is granted in the same cycle as its bid.
- R4: When a class has more than ISSUE_W occupied bidders, exactly the ISSUE_W oldest of them by dispatch order are granted.
- R5: Age order is independent of slot index. An entry dispatched into a low slot after an entry in a high slot is younger.
- R6: Classes are arbitrated independently. Class values 0 and 1 on `disp_cls_i` each receive up to ISSUE_W grants in the same cycle, and an entry of one class never blocks an entry of the other.
- R7: In criticality mode, an entry dispatched with `disp_crit_i`=1 is older than every non-critical entry of its class, whatever the dispatch order. Critical entries are ordered among themselves by dispatch order, and so are non-critical entries.
- R8: When several lanes dispatch in one cycle, lane 0 is older than lane 1.
- R9: A slot granted in cycle t is shown in `freed_o` (bit i = slot i) in cycle t+1. It is not granted again until it is dispatched into anew.
- R10: A freed slot may be dispatched into again, and the new entry is younger than every entry already present in its class.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_vld_i | input | DISP_W | Per-lane dispatch valid; lane 0 is older |
| disp_slot_i | input | DISP_W x SLOT_W | Per-lane target slot, which must be free |
| disp_crit_i | input | DISP_W | Per-lane critical flag (1 = critical) |
| disp_cls_i | input | DISP_W x CLS_W | Per-lane execution class |
| bid_i | input | N_SLOTS | Ready bids, bit i = slot i |
| grant_o | output | N_SLOTS | Slots granted this cycle, bit i = slot i |
| freed_o | output | N_SLOTS | Slots granted in the previous cycle and now empty |

## Verification
`grant_o` is combinational. It reflects the bids of the current cycle and every dispatch taken at an earlier edge. `freed_o` follows `grant_o` by exactly one clock. A dispatch takes effect at the edge it is presented on, so it can first be granted in the following cycle. The driver presents dispatches and bids just after a rising edge and pushes the expected grant and freed vectors for that same cycle. The monitor pops and compares them at the falling edge of that cycle. The expected values come from a sequence-number model: each entry carries a dispatch counter and a critical flag, and per class the smallest keys win.

// File: rtl/ais_pkg.sv
package ais_pkg;

    localparam int unsigned DEF_SLOTS   = 16;
    localparam int unsigned DEF_ISSUE_W = 4;
    localparam int unsigned DEF_CLASSES = 2;
    localparam int unsigned DEF_DISP_W  = 2;

    // Relation a newly dispatched entry takes to one other slot.
    typedef enum logic [1:0] {
        REL_NONE        = 2'd0,
        REL_NEW_YOUNGER = 2'd1,
        REL_NEW_OLDER   = 2'd2
    } rel_e;

    function automatic rel_e relate(
        input logic crit_mode,
        input logic other_occ,
        input logic same_cls,
        input logic new_crit,
        input logic other_crit
    );
        if (!other_occ || !same_cls) return REL_NONE;
        if (crit_mode && new_crit && !other_crit) return REL_NEW_OLDER;
        return REL_NEW_YOUNGER;
    endfunction

endpackage

// File: rtl/ais_slot_state.sv
module ais_slot_state #(
    parameter int unsigned N      = 16,
    parameter int unsigned DW     = 2,
    parameter int unsigned SLOT_W = 4,
    parameter int unsigned CLS_W  = 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [DW-1:0]                disp_vld,
    input  logic [DW-1:0][SLOT_W-1:0]    disp_slot,
    input  logic [DW-1:0]                disp_crit,
    input  logic [DW-1:0][CLS_W-1:0]     disp_cls,
    input  logic [N-1:0]                 grant,
    output logic [N-1:0]                 valid_q,
    output logic [N-1:0]                 crit_q,
    output logic [N-1:0][CLS_W-1:0]      cls_q,
    output logic [N-1:0]                 freed_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            crit_q  <= '0;
            cls_q   <= '0;
            freed_q <= '0;
        end else begin
            valid_q <= valid_q & ~grant;
            freed_q <= grant;
            for (int d = 0; d < int'(DW); d++) begin
                if (disp_vld[d]) begin
                    valid_q[disp_slot[d]] <= 1'b1;
                    crit_q[disp_slot[d]]  <= disp_crit[d];
                    cls_q[disp_slot[d]]   <= disp_cls[d];
                end
            end
        end
    end

endmodule

// File: rtl/ais_age_matrix.sv
module ais_age_matrix
    import ais_pkg::*;
#(
    parameter int unsigned N         = 16,
    parameter int unsigned DW        = 2,
    parameter int unsigned SLOT_W    = 4,
    parameter int unsigned CLS_W     = 1,
    parameter bit          CRIT_MODE = 1'b1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [DW-1:0]                disp_vld,
    input  logic [DW-1:0][SLOT_W-1:0]    disp_slot,
    input  logic [DW-1:0]                disp_crit,
    input  logic [DW-1:0][CLS_W-1:0]     disp_cls,
    input  logic [N-1:0]                 valid_q,
    input  logic [N-1:0]                 crit_q,
    input  logic [N-1:0][CLS_W-1:0]      cls_q,
    output logic [N-1:0][N-1:0]          age_q
);

    logic [N-1:0][N-1:0]     age_n;
    logic [N-1:0]            occ;
    logic [N-1:0]            ccrit;
    logic [N-1:0][CLS_W-1:0] ccls;
    logic [SLOT_W-1:0]       s;
    rel_e                    rel;

    // Lanes are applied in order; a later lane sees the earlier ones as
    // occupied and overwrites the shared bits, so it ends up younger.
    always_comb begin
        age_n = age_q;
        occ   = valid_q;
        ccrit = crit_q;
        ccls  = cls_q;
        s     = '0;
        rel   = REL_NONE;
        for (int d = 0; d < int'(DW); d++) begin
            if (disp_vld[d]) begin
                s = disp_slot[d];
                for (int j = 0; j < int'(N); j++) begin
                    if (SLOT_W'(j) == s) begin
                        age_n[s][j] = 1'b0;
                    end else begin
                        rel = relate(CRIT_MODE, occ[j], ccls[j] == disp_cls[d],
                                     disp_crit[d], ccrit[j]);
                        case (rel)
                            REL_NEW_YOUNGER: begin
                                age_n[s][j] = 1'b1;
                                age_n[j][s] = 1'b0;
                            end
                            REL_NEW_OLDER: begin
                                age_n[s][j] = 1'b0;
                                age_n[j][s] = 1'b1;
                            end
                            default: begin
                                age_n[s][j] = 1'b0;
                                age_n[j][s] = 1'b0;
                            end
                        endcase
                    end
                end
                occ[s]   = 1'b1;
                ccrit[s] = disp_crit[d];
                ccls[s]  = disp_cls[d];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) age_q <= '0;
        else     age_q <= age_n;
    end

endmodule

// File: rtl/ais_row_pick.sv
module ais_row_pick #(
    parameter int unsigned N     = 16,
    parameter int unsigned IW    = 4,
    parameter int unsigned CNT_W = 5
) (
    input  logic [N-1:0] row,
    input  logic [N-1:0] bidv,
    input  logic         self_bid,
    output logic         grant
);

    logic [N-1:0]     masked;
    logic [CNT_W-1:0] older_cnt;

    assign masked = row & bidv;

    always_comb begin
        older_cnt = '0;
        for (int i = 0; i < int'(N); i++) begin
            older_cnt = older_cnt + CNT_W'(masked[i]);
        end
    end

    assign grant = self_bid && (older_cnt < CNT_W'(IW));

endmodule

// File: rtl/age_issue_sel.sv
module age_issue_sel
    import ais_pkg::*;
#(
    parameter int unsigned N_SLOTS   = DEF_SLOTS,
    parameter int unsigned ISSUE_W   = DEF_ISSUE_W,
    parameter int unsigned N_CLASSES = DEF_CLASSES,
    parameter int unsigned DISP_W    = DEF_DISP_W,
    parameter bit          CRIT_MODE = 1'b1,
    localparam int unsigned SLOT_W   = $clog2(N_SLOTS),
    localparam int unsigned CLS_W    = (N_CLASSES > 1) ? $clog2(N_CLASSES) : 1,
    localparam int unsigned CNT_W    = $clog2(N_SLOTS + 1)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [DISP_W-1:0]               disp_vld_i,
    input  logic [DISP_W-1:0][SLOT_W-1:0]   disp_slot_i,
    input  logic [DISP_W-1:0]               disp_crit_i,
    input  logic [DISP_W-1:0][CLS_W-1:0]    disp_cls_i,
    input  logic [N_SLOTS-1:0]              bid_i,
    output logic [N_SLOTS-1:0]              grant_o,
    output logic [N_SLOTS-1:0]              freed_o
);

    logic [N_SLOTS-1:0]              valid_q;
    logic [N_SLOTS-1:0]              crit_q;
    logic [N_SLOTS-1:0][CLS_W-1:0]   cls_q;
    logic [N_SLOTS-1:0][N_SLOTS-1:0] age_q;
    logic [N_SLOTS-1:0]              bidv;

    assign bidv = bid_i & valid_q;

    ais_slot_state #(
        .N(N_SLOTS), .DW(DISP_W), .SLOT_W(SLOT_W), .CLS_W(CLS_W)
    ) u_state (
        .clk(clk), .rst(rst),
        .disp_vld(disp_vld_i), .disp_slot(disp_slot_i),
        .disp_crit(disp_crit_i), .disp_cls(disp_cls_i),
        .grant(grant_o),
        .valid_q(valid_q), .crit_q(crit_q), .cls_q(cls_q), .freed_q(freed_o)
    );

    ais_age_matrix #(
        .N(N_SLOTS), .DW(DISP_W), .SLOT_W(SLOT_W), .CLS_W(CLS_W),
        .CRIT_MODE(CRIT_MODE)
    ) u_matrix (
        .clk(clk), .rst(rst),
        .disp_vld(disp_vld_i), .disp_slot(disp_slot_i),
        .disp_crit(disp_crit_i), .disp_cls(disp_cls_i),
        .valid_q(valid_q), .crit_q(crit_q), .cls_q(cls_q),
        .age_q(age_q)
    );

    for (genvar r = 0; r < int'(N_SLOTS); r++) begin : g_row
        ais_row_pick #(
            .N(N_SLOTS), .IW(ISSUE_W), .CNT_W(CNT_W)
        ) u_pick (
            .row(age_q[r]), .bidv(bidv), .self_bid(bidv[r]), .grant(grant_o[r])
        );
    end

endmodule

// File: rtl/ais_checker.sv
module ais_checker #(
    parameter int unsigned N      = 16,
    parameter int unsigned IW     = 4,
    parameter int unsigned NCLS   = 2,
    parameter int unsigned DW     = 2,
    parameter int unsigned SLOT_W = 4,
    parameter int unsigned CLS_W  = 1
) (
    input logic                      clk,
    input logic                      rst,
    input logic [DW-1:0]             disp_vld_i,
    input logic [DW-1:0][SLOT_W-1:0] disp_slot_i,
    input logic [N-1:0]              bid_i,
    input logic [N-1:0]              grant_o,
    input logic [N-1:0]              freed_o,
    input logic [N-1:0]              valid_q,
    input logic [N-1:0][CLS_W-1:0]   cls_q
);

    AST_GRANT_SUBSET: assert property (@(posedge clk) disable iff (rst)
        (grant_o & ~(bid_i & valid_q)) == '0); // R2

    AST_FREED_ECHO: assert property (@(posedge clk) disable iff (rst)
        (grant_o != '0) |=> (freed_o == $past(grant_o))); // R9

    AST_NO_REGRANT: assert property (@(posedge clk) disable iff (rst)
        (grant_o != '0) |=> ((grant_o & $past(grant_o)) == '0)); // R9

    for (genvar d = 0; d < int'(DW); d++) begin : g_lane
        AST_DISP_FREE_SLOT: assert property (@(posedge clk) disable iff (rst)
            disp_vld_i[d] |-> !valid_q[disp_slot_i[d]]); // R10
    end

    for (genvar k = 0; k < int'(NCLS); k++) begin : g_cls
        logic [N-1:0] in_cls;
        for (genvar i = 0; i < int'(N); i++) begin : g_bit
            assign in_cls[i] = valid_q[i] && (cls_q[i] == CLS_W'(k));
        end

        AST_CLASS_CAP: assert property (@(posedge clk) disable iff (rst)
            $countones(grant_o & in_cls) <= IW); // R6

        AST_FILL_WIDTH: assert property (@(posedge clk) disable iff (rst)
            ($countones(bid_i & in_cls) >= IW) |->
                ($countones(grant_o & in_cls) == IW)); // R4

        AST_ALL_FEW: assert property (@(posedge clk) disable iff (rst)
            ($countones(bid_i & in_cls) < IW) |->
                ((grant_o & in_cls) == (bid_i & in_cls))); // R3
    end

endmodule

bind age_issue_sel ais_checker #(
    .N(N_SLOTS), .IW(ISSUE_W), .NCLS(N_CLASSES), .DW(DISP_W),
    .SLOT_W(SLOT_W), .CLS_W(CLS_W)
) u_chk (
    .clk(clk), .rst(rst),
    .disp_vld_i(disp_vld_i), .disp_slot_i(disp_slot_i),
    .bid_i(bid_i), .grant_o(grant_o), .freed_o(freed_o),
    .valid_q(valid_q), .cls_q(cls_q)
);

// File: tb/age_issue_sel_bench.sv
module age_issue_sel_bench;

    localparam int N  = 16;
    localparam int IW = 4;
    localparam int DW = 2;
    localparam int SW = 4;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [DW-1:0]      disp_vld  = '0;
    logic [DW-1:0][SW-1:0] disp_slot = '0;
    logic [DW-1:0]      disp_crit = '0;
    logic [DW-1:0][0:0] disp_cls  = '0;
    logic [N-1:0]       bid = '0;
    logic [N-1:0]       grant;
    logic [N-1:0]       freed;

    always #2 clk = ~clk;

    age_issue_sel u_age_issue_sel (
        .clk(clk), .rst(rst),
        .disp_vld_i(disp_vld), .disp_slot_i(disp_slot),
        .disp_crit_i(disp_crit), .disp_cls_i(disp_cls),
        .bid_i(bid), .grant_o(grant), .freed_o(freed)
    );

    // Reference model
    bit      m_valid [N];
    bit      m_crit  [N];
    int      m_cls   [N];
    longint  m_seq   [N];
    longint  seq_ctr = 0;
    logic [N-1:0] last_grant = '0;

    // Pending dispatch lanes for the next cycle
    bit l_vld [DW];
    int l_slot[DW];
    int l_cls [DW];
    bit l_crit[DW];

    typedef struct {
        logic [N-1:0] g;
        logic [N-1:0] f;
        string        tag;
    } exp_t;
    exp_t sb[$];

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    function automatic bit older(int j, int i);
        if (m_crit[j] && !m_crit[i]) return 1;
        if (m_crit[j] == m_crit[i] && m_seq[j] < m_seq[i]) return 1;
        return 0;
    endfunction

    function automatic logic [N-1:0] model_grant(logic [N-1:0] b);
        logic [N-1:0] g = '0;
        for (int i = 0; i < N; i++) begin
            if (m_valid[i] && b[i]) begin
                int cnt = 0;
                for (int j = 0; j < N; j++)
                    if (j != i && m_valid[j] && b[j] && m_cls[j] == m_cls[i] && older(j, i))
                        cnt++;
                if (cnt < IW) g[i] = 1'b1;
            end
        end
        return g;
    endfunction

    function automatic bit model_empty();
        for (int i = 0; i < N; i++) if (m_valid[i]) return 0;
        return 1;
    endfunction

    task automatic lane(int d, int slot, int cls, bit crit);
        l_vld[d] = 1; l_slot[d] = slot; l_cls[d] = cls; l_crit[d] = crit;
    endtask

    // Driver: one cycle of stimulus, expected result pushed for this cycle
    task automatic cycle_io(logic [N-1:0] b, string tag);
        exp_t e;
        @(posedge clk);
        #1;
        for (int d = 0; d < DW; d++) begin
            disp_vld[d]  = l_vld[d];
            disp_slot[d] = SW'(l_slot[d]);
            disp_cls[d]  = 1'(l_cls[d]);
            disp_crit[d] = l_crit[d];
        end
        bid   = b;
        e.g   = model_grant(b);
        e.f   = last_grant;
        e.tag = tag;
        sb.push_back(e);
        for (int i = 0; i < N; i++) if (e.g[i]) m_valid[i] = 0;
        last_grant = e.g;
        for (int d = 0; d < DW; d++) begin
            if (l_vld[d]) begin
                m_valid[l_slot[d]] = 1;
                m_crit[l_slot[d]]  = l_crit[d];
                m_cls[l_slot[d]]   = l_cls[d];
                m_seq[l_slot[d]]   = seq_ctr++;
            end
            l_vld[d] = 0;
        end
    endtask

    task automatic drain(string tag);
        for (int k = 0; k < 8 && !model_empty(); k++) cycle_io('1, tag);
        cycle_io('1, tag);
    endtask

    // Monitor
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_chk++;
            if (grant !== e.g || freed !== e.f) begin
                n_fail++;
                $display("FAIL %s: grant=%h freed=%h expected grant=%h freed=%h",
                         e.tag, grant, freed, e.g, e.f);
            end
        end
    end

    initial begin
        for (int d = 0; d < DW; d++) l_vld[d] = 0;
        for (int i = 0; i < N; i++) begin
            m_valid[i] = 0; m_crit[i] = 0; m_cls[i] = 0; m_seq[i] = 0;
        end
        bid = '1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: empty after reset, all bids ignored
        cycle_io('1, "R1 reset state");
        cycle_io('1, "R1 R2 empty slots ignore bids");

        // R5 R8: scattered slots, lane 0 older
        lane(0, 9, 0, 0);  lane(1, 3, 0, 0);  cycle_io('0, "R8 dispatch");
        lane(0, 14, 0, 0); lane(1, 0, 0, 0);  cycle_io('0, "R8 dispatch");
        lane(0, 7, 0, 0);  lane(1, 11, 0, 0); cycle_io('0, "R8 dispatch");
        cycle_io('1, "R4 R5 R8 four oldest of six");
        cycle_io('1, "R3 R9 remaining two granted");
        cycle_io('1, "R9 freed shown, no regrant");
        drain("R2 drain");

        // R6: two classes interleaved
        for (int k = 0; k < 5; k++) begin
            lane(0, 1 + k + (k > 2 ? 1 : 0), 1, 0);
            lane(1, 8 + 2 * k - (k > 2 ? 1 : 0), 0, 0);
            cycle_io('0, "R6 dispatch");
        end
        cycle_io('1, "R6 four per class");
        cycle_io(16'h00FF, "R2 R6 bid subset");
        drain("R6 drain");

        // R7: critical entries jump ahead
        lane(0, 0, 0, 0); lane(1, 1, 0, 0); cycle_io('0, "R7 dispatch");
        lane(0, 2, 0, 0); lane(1, 3, 0, 1); cycle_io('0, "R7 dispatch");
        lane(0, 4, 0, 1); lane(1, 5, 0, 0); cycle_io('0, "R7 dispatch");
        lane(0, 6, 1, 1); lane(1, 7, 1, 0); cycle_io('0, "R7 dispatch");
        cycle_io('1, "R7 critical first");
        cycle_io('1, "R7 leftover non-critical");
        drain("R7 drain");

        // R10: reuse a freed slot
        lane(0, 0, 0, 0); lane(1, 1, 0, 0); cycle_io('0, "R10 dispatch");
        lane(0, 2, 0, 0); lane(1, 3, 0, 0); cycle_io('0, "R10 dispatch");
        lane(0, 4, 0, 0);                   cycle_io('0, "R10 dispatch");
        cycle_io(16'h0001, "R10 grant slot 0 alone");
        lane(0, 0, 0, 0);                   cycle_io('0, "R9 R10 redispatch slot 0");
        cycle_io('1, "R10 reused slot is youngest");
        drain("R10 drain");

        // Random mix
        for (int c = 0; c < 400; c++) begin
            bit taken [N];
            for (int i = 0; i < N; i++) taken[i] = 0;
            for (int d = 0; d < DW; d++) begin
                if ($urandom_range(0, 1) == 1) begin
                    int s = $urandom_range(0, N - 1);
                    for (int t = 0; t < N; t++) begin
                        int q = (s + t) % N;
                        if (!m_valid[q] && !taken[q]) begin
                            taken[q] = 1;
                            lane(d, q, $urandom_range(0, 1), $urandom_range(0, 2) == 0);
                            break;
                        end
                    end
                end
            end
            cycle_io(N'($urandom) | N'($urandom), "R4 R6 R7 random mix");
        end
        drain("R9 final drain");

        @(posedge clk);
        @(posedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R9 watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule